// File: doc/BRIEF.md
# CAN error frame sequencer

This block sits at bit level inside a CAN protocol controller. It acts once per bit, on a sample-point strobe from the bit timing logic. It watches the sampled bus level, the level the node means to drive and the error pulses raised by the frame logic. When an error is found, it takes over the transmit line. It sends the error flag, then waits out any flags that other nodes are still sending, then counts the delimiter and the interframe space. When all of that is done, it tells the frame logic that the node may take part in arbitration again.

Two error sources live inside the block. The first is bit monitoring: while the node transmits, it compares the level it drives with the level it samples. The second is a run-length check on the sampled bits that detects stuffing violations. A checksum error is handled differently from every other error. It is held back for two bits, so the acknowledge slot and its delimiter pass without disturbance, and only then does the flag start. When the node is error-passive, its flag is recessive, so it cannot block the bus.

Top module: `can_errframe_seq`

## Requirements
- R1: A frame error pulse seen at a bit strobe makes the very next bit a flag bit: `tx_out` goes dominant (0) and `err_busy` goes to 1 right after that strobe.
- R2: A checksum error seen at a strobe (with no other error at the same strobe) keeps `tx_out` recessive (1) for the next two bits, covering the acknowledge slot and the acknowledge delimiter. The flag starts with the third bit.
- R3: An error-active node drives exactly 6 dominant flag bits, then releases the line to recessive.
- R4: When `err_passive` is 1, the flag bits are driven recessive (1) instead of dominant.
- R5: After its own flag, the node waits for the first recessive sample, however many dominant bits other nodes add. That sample plus 7 further bits form the 8-bit delimiter, and `tx_out` stays recessive throughout.
- R6: After the delimiter come 3 recessive interframe bits. After the third one, `rejoin` pulses for one clock and `err_busy` returns to 0.
- R7: A dominant sample during the interframe space counts as a start of frame: `sof_seen` pulses, `err_busy` drops to 0, `rejoin` stays 0 and no flag is sent.
- R8: While `tx_active` is 1 and `ack_slot` is 0, a sample that differs from `tx_want` raises a one-clock `bit_err` pulse and starts a flag at the next bit.
- R9: No mismatch is reported during the acknowledge slot, or when the node is not transmitting.
- R10: While `stuff_chk` is 1, the sixth consecutive sample of the same level is a stuff error and starts a flag. Five equal samples are not an error.
- R11: After reset, including a reset in the middle of an error frame, the block is in normal mode: `tx_out` follows `tx_want`, `err_busy` is 0 and every pulse output is 0.
- R12: When a checksum error and an immediate error arrive at the same strobe, the immediate timing wins and the flag starts at the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-clock strobe at each bit's sample point |
| rx_bit | input | 1 | Sampled bus level (1 recessive, 0 dominant) |
| tx_want | input | 1 | Level the frame logic wants to drive this bit |
| tx_active | input | 1 | Node is currently the transmitter |
| ack_slot | input | 1 | Current bit is the acknowledge slot |
| stuff_chk | input | 1 | Stuffing rule applies to the current bits |
| frame_err | input | 1 | Other immediate error from the frame logic (form, acknowledge) |
| crc_err | input | 1 | Checksum mismatch detected |
| err_passive | input | 1 | Node is error-passive |
| tx_out | output | 1 | Level driven to the transmitter |
| err_busy | output | 1 | Error frame in progress |
| bit_err | output | 1 | One-clock pulse on a bit monitoring mismatch |
| rejoin | output | 1 | One-clock pulse: interframe space done, node may arbitrate |
| sof_seen | output | 1 | One-clock pulse: dominant bit seen in interframe space |

## Verification
The hardest case to reach is the delimiter wait while other nodes keep the bus dominant after the node's own six flag bits. It only occurs when the sampled level disagrees with what the node drives. The bench plays the other nodes by holding `rx_bit` dominant for several bits after the node has released the line. It then checks that the delimiter count starts only at the first recessive sample. The checksum case follows a similar pattern: the bench presents a dominant acknowledge slot and then checks that the flag appears two bits late.

// File: rtl/can_efs_pkg.sv
package can_efs_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_CRC_HOLD = 3'd1,
    ST_FLAG     = 3'd2,
    ST_DLM_WAIT = 3'd3,
    ST_DLM      = 3'd4,
    ST_IFS      = 3'd5
  } efs_state_e;
endpackage

// File: rtl/efs_stuff_mon.sv
module efs_stuff_mon #(
  parameter int RUN_LIM = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic chk_en,
  input  logic rx_bit,
  output logic stuff_err
);
  localparam int RUN_W = $clog2(RUN_LIM + 2);
  localparam logic [RUN_W-1:0] RUN_AT_LIM = RUN_W'(RUN_LIM);
  localparam logic [RUN_W-1:0] RUN_SAT    = RUN_W'(RUN_LIM + 1);

  logic [RUN_W-1:0] run_q, run_n;
  logic             last_q, last_n;
  logic             same;

  always_comb begin
    same   = (run_q != '0) && (rx_bit == last_q);
    run_n  = run_q;
    last_n = last_q;
    if (!chk_en) begin
      run_n = '0;
    end else if (bit_tick) begin
      last_n = rx_bit;
      if (!same)                run_n = RUN_W'(1);
      else if (run_q != RUN_SAT) run_n = run_q + 1'b1;
    end
    stuff_err = bit_tick && chk_en && same && (run_q == RUN_AT_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else begin
      run_q  <= run_n;
      last_q <= last_n;
    end
  end

  // R10: run length never passes the saturation point
  p_run_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_SAT);
endmodule

// File: rtl/efs_bit_mon.sv
module efs_bit_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic mon_en,
  input  logic tx_active,
  input  logic ack_slot,
  input  logic tx_want,
  input  logic rx_bit,
  output logic mismatch,
  output logic bit_err_q
);
  always_comb begin
    mismatch = bit_tick && mon_en && tx_active && !ack_slot && (rx_bit != tx_want);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_err_q <= 1'b0;
    else        bit_err_q <= mismatch;
  end

  // R9: acknowledge slot never yields a monitoring error
  p_ack_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && ack_slot) |=> !bit_err_q);
  // R9: a receiving node never yields a monitoring error
  p_rx_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !tx_active) |=> !bit_err_q);
endmodule

// File: rtl/efs_seq_fsm.sv
module efs_seq_fsm
  import can_efs_pkg::*;
#(
  parameter int FLAG_LEN = 6,
  parameter int DLM_LEN  = 8,
  parameter int IFS_LEN  = 3,
  parameter int CRC_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic err_now,
  input  logic err_crc,
  input  logic err_passive,
  input  logic tx_want,
  output logic tx_out,
  output logic in_err,
  output logic mon_en,
  output logic rejoin,
  output logic sof_seen
);
  localparam int MAX_A = (FLAG_LEN > DLM_LEN) ? FLAG_LEN : DLM_LEN;
  localparam int MAX_B = (IFS_LEN > CRC_HOLD) ? IFS_LEN : CRC_HOLD;
  localparam int MAXL  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXL + 1);
  localparam logic [CNT_W-1:0] FLAG_END = CNT_W'(FLAG_LEN - 1);
  localparam logic [CNT_W-1:0] DLM_END  = CNT_W'(DLM_LEN - 2);
  localparam logic [CNT_W-1:0] IFS_END  = CNT_W'(IFS_LEN - 1);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(CRC_HOLD - 1);
  localparam logic [CNT_W-1:0] FLAG_LIM = CNT_W'(FLAG_LEN);

  efs_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rejoin_n, sof_n;

  // next state
  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    rejoin_n = 1'b0;
    sof_n    = 1'b0;
    if (bit_tick) begin
      unique case (state_q)
        ST_NORMAL: begin
          if (err_now) begin
            state_n = ST_FLAG;
            cnt_n   = '0;
          end else if (err_crc) begin
            state_n = ST_CRC_HOLD;
            cnt_n   = '0;
          end
        end
        ST_CRC_HOLD: begin
          if (cnt_q == CRC_END) begin
            state_n = ST_FLAG;
            cnt_n   = '0;
          end else cnt_n = cnt_q + 1'b1;
        end
        ST_FLAG: begin
          if (cnt_q == FLAG_END) begin
            state_n = ST_DLM_WAIT;
            cnt_n   = '0;
          end else cnt_n = cnt_q + 1'b1;
        end
        ST_DLM_WAIT: begin
          if (rx_bit) begin
            state_n = ST_DLM;
            cnt_n   = '0;
          end
        end
        ST_DLM: begin
          if (cnt_q == DLM_END) begin
            state_n = ST_IFS;
            cnt_n   = '0;
          end else cnt_n = cnt_q + 1'b1;
        end
        ST_IFS: begin
          if (!rx_bit) begin
            state_n = ST_NORMAL;
            cnt_n   = '0;
            sof_n   = 1'b1;
          end else if (cnt_q == IFS_END) begin
            state_n  = ST_NORMAL;
            cnt_n    = '0;
            rejoin_n = 1'b1;
          end else cnt_n = cnt_q + 1'b1;
        end
        default: begin
          state_n = ST_NORMAL;
          cnt_n   = '0;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_NORMAL;
      cnt_q    <= '0;
      rejoin   <= 1'b0;
      sof_seen <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      rejoin   <= rejoin_n;
      sof_seen <= sof_n;
    end
  end

  // line drive
  always_comb begin
    unique case (state_q)
      ST_NORMAL: tx_out = tx_want;
      ST_FLAG:   tx_out = err_passive;
      default:   tx_out = 1'b1;
    endcase
    in_err = (state_q != ST_NORMAL);
    mon_en = (state_q == ST_NORMAL);
  end

  p_imm_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && state_q == ST_NORMAL && err_now) |=> (state_q == ST_FLAG && cnt_q == '0));
  p_crc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && state_q == ST_NORMAL && err_crc && !err_now) |=> (state_q == ST_CRC_HOLD));
  p_flag_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLAG) |-> (cnt_q < FLAG_LIM));
  p_wait_rec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && state_q == ST_DLM_WAIT && !rx_bit) |=> (state_q == ST_DLM_WAIT));
  p_rejoin_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rejoin |-> ($past(state_q) == ST_IFS && state_q == ST_NORMAL));
  p_sof_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_seen |-> (state_q == ST_NORMAL && !rejoin));
endmodule

// File: rtl/can_errframe_seq.sv
module can_errframe_seq #(
  parameter int FLAG_LEN  = 6,
  parameter int DLM_LEN   = 8,
  parameter int IFS_LEN   = 3,
  parameter int CRC_HOLD  = 2,
  parameter int STUFF_LIM = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic tx_want,
  input  logic tx_active,
  input  logic ack_slot,
  input  logic stuff_chk,
  input  logic frame_err,
  input  logic crc_err,
  input  logic err_passive,
  output logic tx_out,
  output logic err_busy,
  output logic bit_err,
  output logic rejoin,
  output logic sof_seen
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       mon_en, mismatch, stuff_err, err_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  efs_stuff_mon #(.RUN_LIM(STUFF_LIM)) u_stuff (
    .clk(clk), .rst_n(rst_s_n), .bit_tick(bit_tick), .chk_en(stuff_chk),
    .rx_bit(rx_bit), .stuff_err(stuff_err)
  );

  efs_bit_mon u_bmon (
    .clk(clk), .rst_n(rst_s_n), .bit_tick(bit_tick), .mon_en(mon_en),
    .tx_active(tx_active), .ack_slot(ack_slot), .tx_want(tx_want),
    .rx_bit(rx_bit), .mismatch(mismatch), .bit_err_q(bit_err)
  );

  assign err_now = mismatch | stuff_err | frame_err;

  efs_seq_fsm #(
    .FLAG_LEN(FLAG_LEN), .DLM_LEN(DLM_LEN), .IFS_LEN(IFS_LEN), .CRC_HOLD(CRC_HOLD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .err_now(err_now), .err_crc(crc_err), .err_passive(err_passive),
    .tx_want(tx_want), .tx_out(tx_out), .in_err(err_busy), .mon_en(mon_en),
    .rejoin(rejoin), .sof_seen(sof_seen)
  );

  // R8: a monitoring mismatch always lands in an error frame
  p_biterr_flag_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    bit_err |-> err_busy);
  // R12: a simultaneous immediate error overrides the checksum delay
  p_prio_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bit_tick && !err_busy && crc_err && frame_err) |=> (err_busy && (tx_out == err_passive)));
endmodule

// File: tb/sim_can_errframe_seq.sv
`timescale 1ns/1ps
module sim_can_errframe_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, rx_bit = 1'b1, tx_want = 1'b1, tx_active = 1'b0;
  logic ack_slot = 1'b0, stuff_chk = 1'b0, frame_err = 1'b0, crc_err = 1'b0;
  logic err_passive = 1'b0;
  logic tx_out, err_busy, bit_err, rejoin, sof_seen;
  int   n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  can_errframe_seq u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .tx_want(tx_want), .tx_active(tx_active), .ack_slot(ack_slot),
    .stuff_chk(stuff_chk), .frame_err(frame_err), .crc_err(crc_err),
    .err_passive(err_passive), .tx_out(tx_out), .err_busy(err_busy),
    .bit_err(bit_err), .rejoin(rejoin), .sof_seen(sof_seen)
  );

  // stimulus layout: rx txa txw stf ack frm crc pas | tx busy rj sof be | req
  localparam int NV = 26;
  localparam logic [16:0] VEC [NV] = '{
    17'b0_0_1_1_0_0_0_0_1_0_0_0_0_1010, // R10 five dominant, no error
    17'b0_0_1_1_0_0_0_0_1_0_0_0_0_1010,
    17'b0_0_1_1_0_0_0_0_1_0_0_0_0_1010,
    17'b0_0_1_1_0_0_0_0_1_0_0_0_0_1010,
    17'b0_0_1_1_0_0_0_0_1_0_0_0_0_1010,
    17'b0_0_1_1_0_0_0_0_0_1_0_0_0_1010, // R10 sixth equal bit -> flag
    17'b0_0_1_0_0_0_0_0_0_1_0_0_0_0011, // R3 flag bits 1..5
    17'b0_0_1_0_0_0_0_0_0_1_0_0_0_0011,
    17'b0_0_1_0_0_0_0_0_0_1_0_0_0_0011,
    17'b0_0_1_0_0_0_0_0_0_1_0_0_0_0011,
    17'b0_0_1_0_0_0_0_0_0_1_0_0_0_0011,
    17'b0_0_1_0_0_0_0_0_1_1_0_0_0_0011, // R3 released after six
    17'b0_0_1_0_0_0_0_0_1_1_0_0_0_0101, // R5 other nodes' flags
    17'b0_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b0_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0101, // R5 delimiter bits 1..8
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0101,
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0110, // R6 interframe bits 1..3
    17'b1_0_1_0_0_0_0_0_1_1_0_0_0_0110,
    17'b1_0_1_0_0_0_0_0_1_0_1_0_0_0110
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick  = 1'b0;
    frame_err = 1'b0;
    crc_err   = 1'b0;
  endtask

  task automatic bits(input logic lvl, input int n);
    for (int k = 0; k < n; k++) begin
      rx_bit = lvl;
      tick();
    end
  endtask

  // six flag bits, eight delimiter bits, three interframe bits
  task automatic drain(input string req);
    bits(1'b0, 6);
    chk(req, {31'd0, tx_out}, 32'd1);
    bits(1'b1, 10);
    chk(req, {31'd0, rejoin}, 32'd0);
    bits(1'b1, 1);
    chk(req, {30'd0, rejoin, err_busy}, 32'b10);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  final begin end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11", {27'd0, tx_out, err_busy, bit_err, rejoin, sof_seen}, 32'b10000);
    tx_want = 1'b0;
    #1 chk("R11", {31'd0, tx_out}, 32'd0);
    tx_want = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      rx_bit = VEC[i][16]; tx_active = VEC[i][15]; tx_want = VEC[i][14];
      stuff_chk = VEC[i][13]; ack_slot = VEC[i][12]; frame_err = VEC[i][11];
      crc_err = VEC[i][10]; err_passive = VEC[i][9];
      tick();
      n_chk++;
      if ({tx_out, err_busy, rejoin, sof_seen, bit_err} !== VEC[i][8:4]) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual %b expected %b", VEC[i][3:0], i,
                 {tx_out, err_busy, rejoin, sof_seen, bit_err}, VEC[i][8:4]);
      end
    end
    stuff_chk = 1'b0;

    // R10 alternating runs of five never trip
    stuff_chk = 1'b1;
    bits(1'b0, 5); bits(1'b1, 5); bits(1'b0, 1);
    chk("R10", {31'd0, err_busy}, 32'd0);
    stuff_chk = 1'b0;
    bits(1'b1, 1);

    // R1 immediate flag
    rx_bit = 1'b1; frame_err = 1'b1; tick();
    chk("R1", {30'd0, tx_out, err_busy}, 32'b01);
    drain("R6");

    // R2 checksum delay
    crc_err = 1'b1; rx_bit = 1'b1; tick();
    chk("R2", {30'd0, tx_out, err_busy}, 32'b11);
    bits(1'b0, 1);  // acknowledge slot, dominant from others
    chk("R2", {30'd0, tx_out, err_busy}, 32'b11);
    bits(1'b1, 1);  // acknowledge delimiter
    chk("R2", {30'd0, tx_out, err_busy}, 32'b01);
    drain("R2");

    // R12 both errors at once
    crc_err = 1'b1; frame_err = 1'b1; rx_bit = 1'b1; tick();
    chk("R12", {30'd0, tx_out, err_busy}, 32'b01);
    drain("R12");

    // R4 passive flag
    err_passive = 1'b1; frame_err = 1'b1; tick();
    chk("R4", {30'd0, tx_out, err_busy}, 32'b11);
    bits(1'b0, 2);
    chk("R4", {31'd0, tx_out}, 32'd1);
    bits(1'b0, 4);
    bits(1'b1, 11);
    chk("R4", {30'd0, rejoin, err_busy}, 32'b10);
    err_passive = 1'b0;

    // R7 dominant in interframe space
    frame_err = 1'b1; tick();
    bits(1'b0, 6); bits(1'b1, 9);
    chk("R7", {31'd0, err_busy}, 32'd1);
    bits(1'b0, 1);
    chk("R7", {28'd0, sof_seen, rejoin, err_busy, tx_out}, 32'b1001);
    bits(1'b1, 1);

    // R9 masked monitoring
    tx_active = 1'b1; tx_want = 1'b1; ack_slot = 1'b1;
    bits(1'b0, 1);
    chk("R9", {30'd0, bit_err, err_busy}, 32'b00);
    ack_slot = 1'b0; tx_active = 1'b0;
    bits(1'b0, 1);
    chk("R9", {30'd0, bit_err, err_busy}, 32'b00);
    tx_active = 1'b1;
    bits(1'b1, 1);
    chk("R8", {30'd0, bit_err, err_busy}, 32'b00);
    // R8 mismatch while transmitting
    bits(1'b0, 1);
    chk("R8", {29'd0, bit_err, err_busy, tx_out}, 32'b110);
    @(negedge clk);
    chk("R8", {31'd0, bit_err}, 32'd0);
    tx_active = 1'b0;
    drain("R8");

    // R11 reset in the middle of a flag
    frame_err = 1'b1; tick();
    bits(1'b0, 2);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", {29'd0, err_busy, tx_out, rejoin}, 32'b010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", {31'd0, err_busy}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule